// File: doc/BRIEF.md
# Edge-Aligned PWM Duty Generator

This block turns a duty-cycle value into an edge-aligned pulse-width-modulated output for a single channel. A shared time base supplies the running count, the programmed period value and a strobe that marks each period boundary. Software writes new duty values into a holding buffer at any time. The holding buffer feeds an active duty register, and that register is updated only at a period boundary, so a period already in progress is never cut short or stretched.

Within a period, the output rises when the count restarts at zero and falls when the count equals the active duty. Two duty values are handled as whole-period cases. A duty of zero keeps the output low for the entire period. A duty above the period value keeps it high for the entire period. The duty register is one bit wider than the period, so the whole-period high case can always be expressed.

When the enable is low, the output is forced low and the active duty follows the buffer on every cycle. The first period after enable therefore starts with the most recently written duty. The output is registered, so it responds one clock after the inputs that cause a change.

Top module: `pwm_edge_gen`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `pwm_out` is 0.
- R2: When `en` is 0 at a clock edge, `pwm_out` is 0 after that edge, whatever the other inputs are.
- R3: When `en` is 1 and `bnd` is 1 at an edge, with a nonzero effective duty, `pwm_out` is 1 after that edge. The time base raises `bnd` exactly when `tmr` is 0.
- R4: When `en` is 1 and `bnd` is 0, and `tmr` equals the active duty, which is nonzero and not above `per`, `pwm_out` is 0 after that edge. Between the zero and the match the output holds its value.
- R5: An active duty of 0 keeps `pwm_out` at 0 for the whole period.
- R6: An active duty greater than `per`, compared as unsigned values with `per` zero-extended to 16 bits, keeps `pwm_out` at 1 for the whole period.
- R7: With an active duty equal to `per`, `pwm_out` is 0 only for the cycle that follows the final count, and it rises again at the next zero.
- R8: A duty written through `duty_wr`/`duty_wdata` in the middle of a period has no effect on the output until the next `bnd`. From that boundary on, the new value governs the period.
- R9: A duty write in the same cycle as `bnd` does not enter the period that is starting. The period uses the buffer's previous contents, and the written value takes effect at the boundary after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Generator enable; when low the output is forced low and the buffer is copied to the active duty |
| tmr | input | 15 | Current time-base count |
| per | input | 15 | Programmed period value (the count runs 0 to per) |
| bnd | input | 1 | Period-boundary strobe, high when the count is 0 |
| duty_wr | input | 1 | Write strobe for the duty buffer |
| duty_wdata | input | 16 | Duty value to be buffered |
| pwm_out | output | 1 | Registered active-high PWM output |

## Verification
The checks assume that the time base is well formed. `bnd` is high only when `tmr` is 0, and `tmr` never goes above `per`. One assertion guards this assumption at the inputs. The bench drives the count from its own counter, which wraps from `per` back to 0, and raises `bnd` only on the zero count. The counter is held at zero while the generator is disabled. `per` changes only while the generator is disabled, so no period is truncated by the stimulus itself.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned TMR_W  = 15;
  localparam int unsigned DUTY_W = TMR_W + 1;
  typedef logic [TMR_W-1:0]  tmr_t;
  typedef logic [DUTY_W-1:0] duty_t;
endpackage

// File: rtl/pwm_duty_buf.sv
module pwm_duty_buf #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          bnd,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] duty_act,
  output logic [DW-1:0] duty_eff
);
  logic [DW-1:0] hold_q, hold_d;
  logic [DW-1:0] act_q, act_d;
  logic          act_load;

  // The active duty follows the buffer while disabled and at each boundary.
  assign act_load = !en || bnd;

  always_comb begin
    hold_d = hold_q;
    if (wr) hold_d = wdata;
  end

  always_comb begin
    act_d = act_q;
    if (act_load) act_d = hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      act_q  <= '0;
    end else begin
      if (wr)       hold_q <= hold_d;
      if (act_load) act_q  <= act_d;
    end
  end

  assign duty_act = act_q;
  // At a boundary the period that is starting uses the buffered value.
  assign duty_eff = bnd ? hold_q : act_q;
endmodule

// File: rtl/pwm_cmp.sv
module pwm_cmp #(
  parameter int unsigned TW = 15,
  parameter int unsigned DW = TW + 1
) (
  input  logic          en,
  input  logic          bnd,
  input  logic [TW-1:0] tmr,
  input  logic [TW-1:0] per,
  input  logic [DW-1:0] duty,
  input  logic          cur,
  output logic          nxt
);
  localparam int unsigned PADW = DW - TW;
  logic [DW-1:0] per_ext;
  logic [DW-1:0] tmr_ext;
  logic          duty_zero;
  logic          duty_over;
  logic          duty_hit;

  assign per_ext   = {{PADW{1'b0}}, per};
  assign tmr_ext   = {{PADW{1'b0}}, tmr};
  assign duty_zero = (duty == '0);
  assign duty_over = (duty > per_ext);
  assign duty_hit  = (tmr_ext == duty);

  always_comb begin
    nxt = cur;
    if (!en)            nxt = 1'b0;
    else if (duty_zero) nxt = 1'b0;
    else if (duty_over) nxt = 1'b1;
    else if (bnd)       nxt = 1'b1;
    else if (duty_hit)  nxt = 1'b0;
  end
endmodule

// File: rtl/pwm_edge_gen.sv
module pwm_edge_gen
  import pwm_pkg::*;
#(
  parameter int unsigned TW = TMR_W,
  parameter int unsigned DW = TW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [TW-1:0] tmr,
  input  logic [TW-1:0] per,
  input  logic          bnd,
  input  logic          duty_wr,
  input  logic [DW-1:0] duty_wdata,
  output logic          pwm_out
);
  logic [DW-1:0] duty_act;
  logic [DW-1:0] duty_eff;
  logic          out_q, out_d;

  pwm_duty_buf #(.DW(DW)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .bnd      (bnd),
    .wr       (duty_wr),
    .wdata    (duty_wdata),
    .duty_act (duty_act),
    .duty_eff (duty_eff)
  );

  pwm_cmp #(.TW(TW), .DW(DW)) u_cmp (
    .en   (en),
    .bnd  (bnd),
    .tmr  (tmr),
    .per  (per),
    .duty (duty_eff),
    .cur  (out_q),
    .nxt  (out_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_d;
  end

  assign pwm_out = out_q;
endmodule

// File: rtl/pwm_edge_gen_chk.sv
module pwm_edge_gen_chk #(
  parameter int unsigned TW = 15,
  parameter int unsigned DW = TW + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic [TW-1:0] tmr,
  input logic [TW-1:0] per,
  input logic          bnd,
  input logic [DW-1:0] duty_act,
  input logic [DW-1:0] duty_eff,
  input logic          pwm_out
);
  logic [DW-1:0] per_x;
  logic [DW-1:0] tmr_x;
  assign per_x = {{(DW-TW){1'b0}}, per};
  assign tmr_x = {{(DW-TW){1'b0}}, tmr};

  // Input assumption: the boundary strobe coincides with a zero count
  a_in_bnd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bnd |-> (tmr == '0));

  a_r1_reset_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !pwm_out);

  a_r2_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pwm_out);

  a_r3_rise_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (en && bnd && duty_eff != '0) |=> pwm_out);

  a_r4_fall_at_match: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !bnd && tmr_x == duty_act && duty_act != '0 && duty_act <= per_x) |=> !pwm_out);

  a_r5_zero_duty: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !bnd && duty_act == '0) |=> !pwm_out);

  a_r6_over_period: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !bnd && duty_act > per_x) |=> pwm_out);

  a_r8_duty_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !bnd) |=> (duty_act == $past(duty_act)));
endmodule

bind pwm_edge_gen pwm_edge_gen_chk #(.TW(TW), .DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .tmr      (tmr),
  .per      (per),
  .bnd      (bnd),
  .duty_act (duty_act),
  .duty_eff (duty_eff),
  .pwm_out  (pwm_out)
);

// File: tb/pwm_edge_gen_tb.sv
module pwm_edge_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 15;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic [TW-1:0] tmr = '0;
  logic [TW-1:0] per = '0;
  logic          bnd = 1'b0;
  logic          duty_wr = 1'b0;
  logic [DW-1:0] duty_wdata = '0;
  logic          pwm_out;

  int n_chk = 0;
  int n_err = 0;

  // bench-side model state
  int m_buf = 0, m_act = 0, m_out = 0, t = 0, pv = 0;
  int exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_edge_gen u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .tmr(tmr), .per(per), .bnd(bnd),
    .duty_wr(duty_wr), .duty_wdata(duty_wdata), .pwm_out(pwm_out)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: pwm_out=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Driver: apply one cycle of stimulus and push the expected output.
  task automatic step(input bit e, input bit wr, input int wd, input string phase);
    int eff, ex;
    string tg;
    @(negedge clk);
    en = e; per = TW'(pv); tmr = TW'(t);
    bnd = e && (t == 0);
    duty_wr = wr; duty_wdata = DW'(wd);
    eff = bnd ? m_buf : m_act;
    if (!e)               begin ex = 0;     tg = "R2"; end
    else if (eff == 0)    begin ex = 0;     tg = "R5"; end
    else if (eff > pv)    begin ex = 1;     tg = "R6"; end
    else if (bnd)         begin ex = 1;     tg = "R3"; end
    else if (t == eff)    begin ex = 0;     tg = (eff == pv) ? "R7" : "R4"; end
    else                  begin ex = m_out; tg = "R4"; end
    exp_q.push_back(ex);
    tag_q.push_back({tg, "/", phase});
    if (!e || bnd) m_act = m_buf;
    if (wr) m_buf = wd;
    m_out = ex;
    if (e) t = (t >= pv) ? 0 : t + 1;
    else   t = 0;
  endtask

  task automatic run(input int n, input string phase);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 0, phase);
  endtask

  task automatic write_at(input int at, input int d, input string phase);
    while (t != at) step(1'b1, 1'b0, 0, phase);
    step(1'b1, 1'b1, d, phase);
  endtask

  // Monitor: pop and compare after each edge.
  initial begin
    forever begin
      @(posedge clk); #1;
      if (exp_q.size() > 0) begin
        int e;
        string tg;
        e = exp_q.pop_front();
        tg = tag_q.pop_front();
        check(tg, int'(pwm_out), e);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3);
    check("R1", int'(pwm_out), 0);          // R1 during reset
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(pwm_out), 0);          // R1 after release
    pv = 9;
    step(1'b0, 1'b1, 4, "R2_load");         // R2: disabled, buffer loaded
    step(1'b0, 1'b0, 0, "R2_load");
    run(30, "R3_R4_duty4");                 // R3/R4 basic
    write_at(2, 7, "R8_midwrite");          // R8: mid-period write
    run(30, "R8_after");
    write_at(5, 0, "R5_zero");              // R5
    run(30, "R5_zero");
    write_at(3, 20, "R6_over");             // R6
    run(30, "R6_over");
    write_at(3, 9, "R7_equal");             // R7: duty == period
    run(30, "R7_equal");
    write_at(3, 2, "R9_pre");
    run(9, "R9_pre");
    write_at(0, 6, "R9_bndwrite");          // R9: write in the boundary cycle
    run(25, "R9_after");
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 0, "R2_off");  // R2
    pv = 3;
    step(1'b0, 1'b1, 1, "R2_reload");
    run(20, "R4_short_duty1");
    write_at(1, 3, "R7_short");
    run(20, "R7_short");
    step(1'b0, 1'b0, 0, "R2_final");
    @(negedge clk); @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule